// File: doc/BRIEF.md
# UART Modem Handshake Unit

This block handles the modem-handshake lines of one serial channel. A small control register drives two active-low handshake outputs: one tells the remote end that data may be sent to this end, and the other tells it that this end is ready to open a link. Two active-low handshake inputs come from the remote end. Each is synchronized and shown in a status byte as an inverted, active-high level. Each also keeps a sticky flag that records a change of level. Reading the status byte clears the flags.

A modem-status interrupt request is the OR of the two change flags, gated by an enable bit. A loopback control bit parks both outputs at their idle high level. In loopback the status inputs are fed internally from the two control bits instead of the external pins, so software can exercise the status path without a partner. Baud-rate generation, FIFOs, infrared coding and automatic flow control are handled elsewhere.

Top module: `mdm_unit`

## Requirements
- R1: Writing the control register with bit 1 set and bit 2 clear drives `rts_n` low from the next cycle. With bit 1 clear, `rts_n` is high.
- R2: Writing the control register with bit 0 set and bit 2 clear drives `dtr_n` low from the next cycle. With bit 0 clear, `dtr_n` is high.
- R3: After reset, `rts_n` and `dtr_n` are 1 and `irq` is 0. With both handshake pins held high, `stat_rdata` reads 0x00.
- R4: While control bit 2 (loopback) is set, `rts_n` and `dtr_n` stay at 1 whatever control bits 1 and 0 hold.
- R5: Status bit 4 is the complement of `cts_n` and status bit 5 is the complement of `dsr_n`. A pin change shows in the status byte after the second rising clock edge. Status bits 2, 3, 6 and 7 read 0.
- R6: Status bit 0 (CTS changed) and status bit 1 (DSR changed) set one edge after the synchronized level changes, which is three edges after the pin change. They stay set until a status read.
- R7: While `stat_rd` is high, `stat_rdata` shows the flags as they were before the read. Bits 0 and 1 are clear after that clock edge.
- R8: If a new synchronized change arrives in the same cycle as a status read, the flag for that line is set after the edge rather than cleared.
- R9: `irq` is 1 exactly when the interrupt enable (written through `ien_wr`/`ien_wdata`) is 1 and either change flag is set. Clearing the enable or clearing the flags drops `irq` after the next edge.
- R10: In loopback, the CTS status follows control bit 1 and the DSR status follows control bit 0, through the same synchronizer. A set control bit reads as status 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 3 | Control data: bit 0 DTR, bit 1 RTS, bit 2 loopback |
| ien_wr | input | 1 | Interrupt-enable write strobe |
| ien_wdata | input | 1 | Interrupt-enable value |
| stat_rd | input | 1 | Status read strobe (clears change flags) |
| stat_rdata | output | 8 | Status byte |
| cts_n | input | 1 | Active-low clear-to-send pin |
| dsr_n | input | 1 | Active-low data-set-ready pin |
| rts_n | output | 1 | Active-low request-to-send pin |
| dtr_n | output | 1 | Active-low data-terminal-ready pin |
| irq | output | 1 | Modem-status interrupt request |

## Verification
The bench counts edges from each pin change. This catches a design that shows a level one cycle early, which means a missing synchronizer stage, or one that sets a flag before the synchronized level changes. It issues a status read in the very cycle a second change is detected. A design that lets the clear win would lose that event and report the flag as 0. It moves into and out of loopback with pins and control bits that disagree. A design that does not park the outputs, or that does not route control bits 1 and 0 to the status bits, gives wrong handshake levels or status bits. It also toggles the enable while a flag stays sticky. A design that latches the interrupt, or that ignores the enable, leaves `irq` in the wrong state.

// File: rtl/mdm_pkg.sv
// Package: field positions and widths shared by the modem handshake unit.
// Assumes: control and status layouts are fixed; only the widths below are shared.
package mdm_pkg;
    localparam int CTL_W    = 3;
    localparam int CTL_DTR  = 0;
    localparam int CTL_RTS  = 1;
    localparam int CTL_LOOP = 2;

    localparam int STAT_W    = 8;
    localparam int STAT_DCTS = 0;
    localparam int STAT_DDSR = 1;
    localparam int STAT_CTS  = 4;
    localparam int STAT_DSR  = 5;

    localparam int LINES = 2;  // index 0 = CTS, index 1 = DSR

    typedef struct packed {
        logic dsr;
        logic cts;
    } mdm_lines_t;
endpackage

// File: rtl/mdm_sync.sv
// Module: multi-stage level synchronizer for asynchronous handshake inputs.
// Assumes: each bit is an independent slow level; reset loads RESET_VAL into every stage.
module mdm_sync #(
    parameter int            W         = 2,
    parameter int            STAGES    = 2,
    parameter logic [W-1:0]  RESET_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Purpose: first stage samples the asynchronous input.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[0] <= RESET_VAL;
                    else        stg[0] <= d;
                end
            end else begin : g_next
                // Purpose: later stages shift the sampled level along.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[s] <= RESET_VAL;
                    else        stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/mdm_chg_track.sv
// Module: per-line change detector with sticky flags cleared by a read strobe.
// Assumes: lvl is already synchronous; a change in the clearing cycle wins over the clear.
module mdm_chg_track #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    input  logic         clr,
    output logic [W-1:0] chg,
    output logic [W-1:0] flag
);
    logic [W-1:0] prev_q;
    logic [W-1:0] flag_q;

    // Purpose: remember last synchronized level; reset matches idle pins.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= lvl;
    end

    assign chg = lvl ^ prev_q;

    // Purpose: sticky flags; set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (flag_q & ~{W{clr}}) | chg;
    end

    assign flag = flag_q;

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_chk
            a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
                (flag[i] && !clr) |=> flag[i]);
            a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
                (clr && chg[i]) |=> flag[i]);
            a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
                (clr && !chg[i]) |=> !flag[i]);
        end
    endgenerate
endmodule

// File: rtl/mdm_ctl_reg.sv
// Module: control and interrupt-enable register, driving the active-low handshake outputs.
// Assumes: write strobes are single-cycle qualified; loopback parks outputs high.
module mdm_ctl_reg
    import mdm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             ien_wr,
    input  logic             ien_wdata,
    output logic             rts_bit,
    output logic             dtr_bit,
    output logic             loop_on,
    output logic             ien,
    output logic             rts_n,
    output logic             dtr_n
);
    logic [CTL_W-1:0] ctl_q;
    logic             ien_q;

    // Purpose: hold the control bits written by software.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl_q <= '0;
        else if (ctl_wr) ctl_q <= ctl_wdata;
    end

    // Purpose: hold the modem-status interrupt enable.
    always_ff @(posedge clk) begin
        if (!rst_n)      ien_q <= 1'b0;
        else if (ien_wr) ien_q <= ien_wdata;
    end

    assign rts_bit = ctl_q[CTL_RTS];
    assign dtr_bit = ctl_q[CTL_DTR];
    assign loop_on = ctl_q[CTL_LOOP];
    assign ien     = ien_q;

    // Purpose: outputs are active low and forced idle during loopback.
    always_comb begin
        rts_n = loop_on | ~rts_bit;
        dtr_n = loop_on | ~dtr_bit;
    end

    a_r1_rts_write: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_wdata[CTL_RTS] && !ctl_wdata[CTL_LOOP]) |=> !rts_n);
    a_r2_dtr_write: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_wdata[CTL_DTR] && !ctl_wdata[CTL_LOOP]) |=> !dtr_n);
    a_r4_loop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_wdata[CTL_LOOP]) |=> (rts_n && dtr_n));
endmodule

// File: rtl/mdm_unit.sv
// Module: modem handshake unit top: control outputs, synchronized status, change flags, interrupt.
// Assumes: cts_n/dsr_n are asynchronous; status byte is combinational from registered state.
module mdm_unit
    import mdm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [CTL_W-1:0]  ctl_wdata,
    input  logic              ien_wr,
    input  logic              ien_wdata,
    input  logic              stat_rd,
    output logic [STAT_W-1:0] stat_rdata,
    input  logic              cts_n,
    input  logic              dsr_n,
    output logic              rts_n,
    output logic              dtr_n,
    output logic              irq
);
    logic       rts_bit, dtr_bit, loop_on, ien;
    mdm_lines_t raw_n, sync_n;
    logic [LINES-1:0] chg, flag;

    mdm_ctl_reg u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (ctl_wr),
        .ctl_wdata (ctl_wdata),
        .ien_wr    (ien_wr),
        .ien_wdata (ien_wdata),
        .rts_bit   (rts_bit),
        .dtr_bit   (dtr_bit),
        .loop_on   (loop_on),
        .ien       (ien),
        .rts_n     (rts_n),
        .dtr_n     (dtr_n)
    );

    // Purpose: choose pins or looped-back control bits as status source.
    always_comb begin
        if (loop_on) begin
            raw_n.cts = ~rts_bit;
            raw_n.dsr = ~dtr_bit;
        end else begin
            raw_n.cts = cts_n;
            raw_n.dsr = dsr_n;
        end
    end

    mdm_sync #(
        .W         (LINES),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL ({LINES{1'b1}})
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_n),
        .q     (sync_n)
    );

    mdm_chg_track #(.W(LINES)) u_chg (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (sync_n),
        .clr   (stat_rd),
        .chg   (chg),
        .flag  (flag)
    );

    // Purpose: assemble the status byte from flags and inverted levels.
    always_comb begin
        stat_rdata            = '0;
        stat_rdata[STAT_DCTS] = flag[0];
        stat_rdata[STAT_DDSR] = flag[1];
        stat_rdata[STAT_CTS]  = ~sync_n.cts;
        stat_rdata[STAT_DSR]  = ~sync_n.dsr;
    end

    assign irq = ien & (|flag);

    a_r9_irq_disable: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_wr && !ien_wdata) |=> !irq);
    a_r9_irq_read: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !ien_wr && (chg == '0)) |=> !irq);
    a_r6_irq_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        (ien && !ien_wr && (chg != '0)) |=> irq);
endmodule

// File: tb/sim_mdm_unit.sv
module sim_mdm_unit;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [2:0] ctl_wdata = '0;
    logic       ien_wr = 1'b0;
    logic       ien_wdata = 1'b0;
    logic       stat_rd = 1'b0;
    logic [7:0] stat_rdata;
    logic       cts_n = 1'b1;
    logic       dsr_n = 1'b1;
    logic       rts_n, dtr_n, irq;

    int n_run = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    mdm_unit u0 (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ien_wr(ien_wr), .ien_wdata(ien_wdata), .stat_rd(stat_rd),
        .stat_rdata(stat_rdata), .cts_n(cts_n), .dsr_n(dsr_n),
        .rts_n(rts_n), .dtr_n(dtr_n), .irq(irq)
    );

    // vector bits: [7]cts_n [6]dsr_n [5]rts bit [4]dtr bit [3]loop [2]ien [1]exp rts_n [0]exp dtr_n
    localparam logic [7:0] VEC [8] = '{
        8'b1100_0111, 8'b0110_0101, 8'b0001_0010, 8'b1011_0100,
        8'b1111_1111, 8'b0000_1111, 8'b1001_1011, 8'b0100_0111
    };

    task automatic tick(input int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_read(output logic [7:0] val);
        stat_rd = 1'b1;
        #1 val = stat_rdata;
        tick();
        stat_rd = 1'b0;
    endtask

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        logic p_c, p_d, p_loop, m_c, m_d, f_c, f_d, fc, fd;
        tick(3);
        rst_n = 1'b1;
        tick();
        // R3 reset state
        check("R3 rts_n", rts_n, 1);
        check("R3 dtr_n", dtr_n, 1);
        check("R3 irq", irq, 0);
        check("R3 status", stat_rdata, 8'h00);

        p_c = 1; p_d = 1; p_loop = 0;
        for (int v = 0; v < 8; v++) begin
            logic [7:0] e;
            e = VEC[v];
            cts_n = e[7]; dsr_n = e[6];
            ctl_wr = 1; ctl_wdata = {e[3], e[5], e[4]};
            ien_wr = 1; ien_wdata = e[2];
            tick();
            ctl_wr = 0; ien_wr = 0;
            tick(4);
            // model: before new loop bit acts, source is pins unless previously looped
            m_c = p_loop ? p_c : e[7];
            m_d = p_loop ? p_d : e[6];
            f_c = e[3] ? ~e[5] : e[7];
            f_d = e[3] ? ~e[4] : e[6];
            fc = (m_c != p_c) | (f_c != m_c);
            fd = (m_d != p_d) | (f_d != m_d);
            check($sformatf("R1/R4 rts_n vec%0d", v), rts_n, e[1]);
            check($sformatf("R2/R4 dtr_n vec%0d", v), dtr_n, e[0]);
            check($sformatf("R9 irq vec%0d", v), irq, e[2] & (fc | fd));
            do_read(rd);
            check($sformatf("R5/R6/R10 status vec%0d", v), rd,
                  {2'b00, ~f_d, ~f_c, 2'b00, fd, fc});
            #1 check($sformatf("R7 cleared vec%0d", v), stat_rdata[1:0], 2'b00);
            p_c = f_c; p_d = f_d; p_loop = e[3];
        end

        // Back to a known state: pins idle, no loopback, enable on, flags clear.
        cts_n = 1; dsr_n = 1;
        ctl_wr = 1; ctl_wdata = 3'b000; ien_wr = 1; ien_wdata = 1;
        tick(); ctl_wr = 0; ien_wr = 0;
        tick(4);
        do_read(rd);
        check("R7 idle clear", stat_rdata[1:0], 2'b00);

        // R5/R6 edge timing of a CTS change
        cts_n = 0;
        tick();
        check("R5 one edge: level unchanged", stat_rdata[4], 0);
        tick();
        check("R5 two edges: level shown", stat_rdata[4], 1);
        check("R6 two edges: flag not yet", stat_rdata[0], 0);
        tick();
        check("R6 three edges: flag set", stat_rdata[0], 1);
        check("R9 irq raised", irq, 1);

        // R9 enable gating with sticky flag
        ien_wr = 1; ien_wdata = 0; tick(); ien_wr = 0;
        check("R9 irq off when disabled", irq, 0);
        ien_wr = 1; ien_wdata = 1; tick(); ien_wr = 0;
        check("R9 irq back with sticky flag", irq, 1);

        // R8 read coinciding with a new change
        cts_n = 1;
        tick(2);
        do_read(rd);
        check("R8 read shows old flag", rd[0], 1);
        check("R8 set wins over clear", stat_rdata[0], 1);
        do_read(rd);
        check("R7 later read clears", stat_rdata[0], 0);
        check("R9 irq drops after read", irq, 0);

        // R6 DSR flag alone
        dsr_n = 0;
        tick(3);
        check("R6 DSR flag", stat_rdata[1:0], 2'b10);
        check("R5 DSR level", stat_rdata[5], 1);
        do_read(rd);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule